// File: doc/BRIEF.md
# Performance Monitor User Access Gate

This block sits between a core's special-register access path and the performance-monitor register file. Each request carries a read/write flag, a register number, write data and a privilege flag. The block decodes the number. It decides whether a user-mode access is legal from a 2-bit access mode field in monitor control register 0. For a legal access it applies a per-register visibility mask and translates the user register number to its privileged copy. For an illegal access it reports the fault class that the pipeline must raise.

The register file looks up the current value of the mapped register in the same cycle, using the combinational `map_num_o`, and returns it on `cur_data_i`. The block registers its decision into a one-cycle response. The response carries masked read data, or a write strobe with merged write data, and a 2-bit fault code. A write that lands on control register 0 also raises a resync pulse. That write can change the mode or the freeze state, so the pipeline must refetch.

Top module: `pmu_user_gate`

## Requirements
- R1: A user read of a monitor register (control 0, control 2, control A, counters 1 to 6) faults with facility-unavailable (code 2'b01) when the mode is 2'b01. Every other mode allows the read. The mode is bits [MODE_LSB+1:MODE_LSB] of `ctrl0_i`.
- R2: A user write of a monitor register is allowed only in modes 2'b10 and 2'b11. Mode 2'b01 gives facility-unavailable (2'b01). Mode 2'b00 gives emulation-assist (2'b10).
- R3: In mode 2'b11, a user read or write of counter 5 or counter 6 gives facility-unavailable. Counter 4 and below stay accessible in that mode. In mode 2'b00, a write to counter 5 or 6 gives emulation-assist.
- R4: A user access to control 0 sees only the bits set in CTRL0_UMASK. These are the freeze bit (31), the alert-enable bit (26) and the alert-occurred bit (7). All other bits read as zero.
- R5: A user access to control 2 sees only the per-counter user-freeze bits in CTRL2_UMASK (bits 47:42). Other bits read as zero. On a user write they keep their current value.
- R6: A masked user write produces (current AND NOT mask) OR (data AND mask).
- R7: A user monitor register number maps to the privileged number by adding MAP_OFS (0x10). `map_num_o` carries the mapped number in the request cycle, and `wr_num_o` carries it in the response.
- R8: A privileged access (`req_user_i`=0) never faults. It uses the number unchanged and reads or writes the full register width.
- R9: The response appears one cycle after the request. A faulting access gives no write strobe and zero read and write data. A cycle with no request gives no response and no strobe. Under reset all outputs are zero.
- R10: `resync_o` pulses with every accepted write whose mapped number is privileged control 0.
- R11: A user access to a number outside the monitor registers passes through unchanged, with no fault and full data.
- R12: A user access to control A or to an allowed counter moves the full register width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_user_i | input | 1 | 1 = user (problem state) access |
| req_num_i | input | NUM_W | Requested register number |
| req_wdata_i | input | DATA_W | Write data |
| ctrl0_i | input | DATA_W | Current control register 0 value (mode source) |
| cur_data_i | input | DATA_W | Current value of register `map_num_o` |
| map_num_o | output | NUM_W | Mapped register number, combinational |
| rsp_valid_o | output | 1 | Response valid |
| fault_o | output | 2 | 00 none, 01 facility-unavailable, 10 emulation-assist |
| rdata_o | output | DATA_W | Read data after masking |
| wr_en_o | output | 1 | Write strobe |
| wr_num_o | output | NUM_W | Register number to write |
| wr_data_o | output | DATA_W | Merged write data |
| resync_o | output | 1 | Pulse after a control 0 write |

## Verification
The bench builds the block with its default parameters: 64-bit data, 10-bit register numbers, six counters with the excluded pair starting at counter 5, and the mode field at bit 18. With these values, every mode and access direction can be exercised against each register class. This includes the boundary between counter 4 and counter 5 in mode 2'b11 and the mask merge with data that overlaps both masked and unmasked bits. Privileged accesses to both user and privileged numbers show that mapping and masking apply only in user mode.

// File: rtl/pmu_gate_pkg.sv
package pmu_gate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_FAC  = 2'd1,
    FLT_EMU  = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    RK_OTHER,
    RK_CTRL0,
    RK_CTRL2,
    RK_CTRLA,
    RK_CNT,
    RK_CNT_HI
  } reg_kind_e;
endpackage

// File: rtl/pmu_gate_decode.sv
module pmu_gate_decode
  import pmu_gate_pkg::*;
#(
  parameter int unsigned NUM_W      = 10,
  parameter int unsigned CTRL0_U    = 'h1A0,
  parameter int unsigned CTRL2_U    = 'h1A1,
  parameter int unsigned CTRLA_U    = 'h1A2,
  parameter int unsigned CNT_U_BASE = 'h1A8,
  parameter int unsigned NUM_CNT    = 6,
  parameter int unsigned HI_FIRST   = 4,
  parameter int unsigned MAP_OFS    = 'h10
) (
  input  logic             user_i,
  input  logic [NUM_W-1:0] num_i,
  output reg_kind_e        kind_o,
  output logic [NUM_W-1:0] map_num_o
);
  logic [NUM_CNT-1:0] cnt_hit;
  logic [NUM_CNT-1:0] cnt_hi;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign cnt_hit[i] = (num_i == NUM_W'(CNT_U_BASE + i));
    assign cnt_hi[i]  = (i >= HI_FIRST);
  end

  always_comb begin
    kind_o = RK_OTHER;
    if (user_i) begin
      if (num_i == NUM_W'(CTRL0_U))      kind_o = RK_CTRL0;
      else if (num_i == NUM_W'(CTRL2_U)) kind_o = RK_CTRL2;
      else if (num_i == NUM_W'(CTRLA_U)) kind_o = RK_CTRLA;
      else if ((cnt_hit & cnt_hi) != '0) kind_o = RK_CNT_HI;
      else if (cnt_hit != '0)            kind_o = RK_CNT;
    end
    map_num_o = (kind_o == RK_OTHER) ? num_i : num_i + NUM_W'(MAP_OFS);
  end
endmodule

// File: rtl/pmu_gate_perm.sv
module pmu_gate_perm
  import pmu_gate_pkg::*;
(
  input  logic       user_i,
  input  logic       write_i,
  input  logic [1:0] mode_i,
  input  reg_kind_e  kind_i,
  output fault_e     fault_o
);
  always_comb begin
    fault_o = FLT_NONE;
    if (user_i && kind_i != RK_OTHER) begin
      if (kind_i == RK_CNT_HI && mode_i == 2'b11) begin
        fault_o = FLT_FAC;
      end else if (!write_i) begin
        if (mode_i == 2'b01) fault_o = FLT_FAC;
      end else if (!mode_i[1]) begin
        fault_o = mode_i[0] ? FLT_FAC : FLT_EMU;
      end
    end
  end
endmodule

// File: rtl/pmu_gate_merge.sv
module pmu_gate_merge #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] rd_o,
  output logic [DATA_W-1:0] wr_o
);
  assign rd_o = cur_i & mask_i;
  assign wr_o = (cur_i & ~mask_i) | (wdata_i & mask_i);
endmodule

// File: rtl/pmu_user_gate.sv
module pmu_user_gate
  import pmu_gate_pkg::*;
#(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned NUM_W       = 10,
  parameter int unsigned MODE_LSB    = 18,
  parameter int unsigned CTRL0_U     = 'h1A0,
  parameter int unsigned CTRL2_U     = 'h1A1,
  parameter int unsigned CTRLA_U     = 'h1A2,
  parameter int unsigned CNT_U_BASE  = 'h1A8,
  parameter int unsigned NUM_CNT     = 6,
  parameter int unsigned HI_FIRST    = 4,
  parameter int unsigned MAP_OFS     = 'h10,
  parameter logic [63:0] CTRL0_UMASK = 64'h0000_0000_8400_0080,
  parameter logic [63:0] CTRL2_UMASK = 64'h0000_FC00_0000_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_user_i,
  input  logic [NUM_W-1:0]  req_num_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] ctrl0_i,
  input  logic [DATA_W-1:0] cur_data_i,
  output logic [NUM_W-1:0]  map_num_o,
  output logic              rsp_valid_o,
  output logic [1:0]        fault_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wr_en_o,
  output logic [NUM_W-1:0]  wr_num_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              resync_o
);
  localparam logic [DATA_W-1:0] M0      = DATA_W'(CTRL0_UMASK);
  localparam logic [DATA_W-1:0] M2      = DATA_W'(CTRL2_UMASK);
  localparam logic [NUM_W-1:0]  CTRL0_P = NUM_W'(CTRL0_U + MAP_OFS);

  reg_kind_e         kind;
  fault_e            fault;
  logic [1:0]        mode;
  logic [DATA_W-1:0] mask, rd_view, wr_val;
  logic              ok;

  assign mode = ctrl0_i[MODE_LSB +: 2];

  pmu_gate_decode #(
    .NUM_W(NUM_W), .CTRL0_U(CTRL0_U), .CTRL2_U(CTRL2_U), .CTRLA_U(CTRLA_U),
    .CNT_U_BASE(CNT_U_BASE), .NUM_CNT(NUM_CNT), .HI_FIRST(HI_FIRST), .MAP_OFS(MAP_OFS)
  ) i_decode (
    .user_i   (req_user_i),
    .num_i    (req_num_i),
    .kind_o   (kind),
    .map_num_o(map_num_o)
  );

  pmu_gate_perm i_perm (
    .user_i (req_user_i),
    .write_i(req_write_i),
    .mode_i (mode),
    .kind_i (kind),
    .fault_o(fault)
  );

  // user kinds only; privileged accesses decode as RK_OTHER and see all bits
  always_comb begin
    unique case (kind)
      RK_CTRL0: mask = M0;
      RK_CTRL2: mask = M2;
      default:  mask = '1;
    endcase
  end

  pmu_gate_merge #(.DATA_W(DATA_W)) i_merge (
    .cur_i  (cur_data_i),
    .wdata_i(req_wdata_i),
    .mask_i (mask),
    .rd_o   (rd_view),
    .wr_o   (wr_val)
  );

  assign ok = req_valid_i && (fault == FLT_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      fault_o     <= FLT_NONE;
      rdata_o     <= '0;
      wr_en_o     <= 1'b0;
      wr_num_o    <= '0;
      wr_data_o   <= '0;
      resync_o    <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      fault_o     <= req_valid_i ? fault : FLT_NONE;
      rdata_o     <= (ok && !req_write_i) ? rd_view : '0;
      wr_en_o     <= ok && req_write_i;
      wr_num_o    <= map_num_o;
      wr_data_o   <= (ok && req_write_i) ? wr_val : '0;
      resync_o    <= ok && req_write_i && (map_num_o == CTRL0_P);
    end
  end
endmodule

// File: rtl/pmu_user_gate_chk.sv
module pmu_user_gate_chk #(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned NUM_W       = 10,
  parameter int unsigned MODE_LSB    = 18,
  parameter int unsigned CTRL0_U     = 'h1A0,
  parameter int unsigned CTRL2_U     = 'h1A1,
  parameter int unsigned MAP_OFS     = 'h10,
  parameter logic [63:0] CTRL2_UMASK = 64'h0000_FC00_0000_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic              req_user_i,
  input logic [NUM_W-1:0]  req_num_i,
  input logic [DATA_W-1:0] ctrl0_i,
  input logic [DATA_W-1:0] cur_data_i,
  input logic              rsp_valid_o,
  input logic [1:0]        fault_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              wr_en_o,
  input logic [NUM_W-1:0]  wr_num_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              resync_o
);
  localparam logic [DATA_W-1:0] M2 = DATA_W'(CTRL2_UMASK);
  logic [1:0] mode;
  assign mode = ctrl0_i[MODE_LSB +: 2];

  a_r1_read_mode01_fac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_user_i && !req_write_i && req_num_i == NUM_W'(CTRL0_U) && mode == 2'b01)
    |=> fault_o == 2'b01);

  a_r2_write_mode00_emu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_user_i && req_write_i && req_num_i == NUM_W'(CTRL0_U) && mode == 2'b00)
    |=> fault_o == 2'b10);

  a_r5_ctrl2_keeps_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_user_i && req_write_i && req_num_i == NUM_W'(CTRL2_U) && mode[1])
    |=> wr_en_o && ((wr_data_o & ~M2) == ($past(cur_data_i) & ~M2)));

  a_r8_priv_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_user_i) |=> fault_o == 2'b00);

  a_r9_fault_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o != 2'b00) |-> (!wr_en_o && rdata_o == '0 && wr_data_o == '0));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !wr_en_o));

  a_r10_resync_ctrl0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> (wr_en_o && wr_num_o == NUM_W'(CTRL0_U + MAP_OFS)));
endmodule

bind pmu_user_gate pmu_user_gate_chk #(
  .DATA_W(DATA_W), .NUM_W(NUM_W), .MODE_LSB(MODE_LSB), .CTRL0_U(CTRL0_U),
  .CTRL2_U(CTRL2_U), .MAP_OFS(MAP_OFS), .CTRL2_UMASK(CTRL2_UMASK)
) i_chk (.*);

// File: tb/test_pmu_user_gate.sv
module test_pmu_user_gate;
  localparam logic [63:0] W  = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] A  = 64'hFFFF_0000_FFFF_0000;
  localparam logic [63:0] C2 = 64'h0000_FFFF_0000_FFFF;

  typedef struct packed {
    logic        wr;
    logic        usr;
    logic [1:0]  mode;
    logic [9:0]  num;
    logic [63:0] cur;
    logic [1:0]  flt;
    logic [9:0]  mnum;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 2'b10, 10'h1A0, A,  2'd0, 10'h1B0, 64'h0000_0000_8400_0000, 8'd4},  // R4 read mask
    '{1'b1, 1'b1, 2'b11, 10'h1A0, A,  2'd0, 10'h1B0, 64'hFFFF_0000_FBFF_0080, 8'd6},  // R6 R4 merge
    '{1'b0, 1'b1, 2'b01, 10'h1A0, A,  2'd1, 10'h1B0, 64'h0,                  8'd1},  // R1 mode 01
    '{1'b0, 1'b1, 2'b00, 10'h1A2, A,  2'd0, 10'h1B2, A,                      8'd1},  // R1 mode 00 ok
    '{1'b1, 1'b1, 2'b00, 10'h1A0, A,  2'd2, 10'h1B0, 64'h0,                  8'd2},  // R2 emu
    '{1'b1, 1'b1, 2'b01, 10'h1A8, A,  2'd1, 10'h1B8, 64'h0,                  8'd2},  // R2 fac
    '{1'b1, 1'b1, 2'b11, 10'h1A8, A,  2'd0, 10'h1B8, W,                      8'd7},  // R7 counter map
    '{1'b1, 1'b1, 2'b10, 10'h1A1, C2, 2'd0, 10'h1B1, 64'h0000_47FF_0000_FFFF, 8'd5},  // R5 merge
    '{1'b0, 1'b1, 2'b00, 10'h1A1, C2, 2'd0, 10'h1B1, 64'h0000_FC00_0000_0000, 8'd5},  // R5 read mask
    '{1'b0, 1'b1, 2'b11, 10'h1AC, A,  2'd1, 10'h1BC, 64'h0,                  8'd3},  // R3 cnt5 read
    '{1'b1, 1'b1, 2'b11, 10'h1AD, A,  2'd1, 10'h1BD, 64'h0,                  8'd3},  // R3 cnt6 write
    '{1'b0, 1'b1, 2'b11, 10'h1AB, A,  2'd0, 10'h1BB, A,                      8'd3},  // R3 cnt4 boundary
    '{1'b0, 1'b1, 2'b10, 10'h1AC, A,  2'd0, 10'h1BC, A,                      8'd3},  // R3 cnt5 mode 10
    '{1'b1, 1'b1, 2'b00, 10'h1AD, A,  2'd2, 10'h1BD, 64'h0,                  8'd3},  // R3 cnt6 mode 00
    '{1'b0, 1'b0, 2'b01, 10'h1B0, A,  2'd0, 10'h1B0, A,                      8'd8},  // R8 priv read
    '{1'b1, 1'b0, 2'b00, 10'h1B0, A,  2'd0, 10'h1B0, W,                      8'd8},  // R8 R10 priv write
    '{1'b1, 1'b1, 2'b10, 10'h050, A,  2'd0, 10'h050, W,                      8'd11}, // R11 write
    '{1'b0, 1'b1, 2'b01, 10'h050, A,  2'd0, 10'h050, A,                      8'd11}, // R11 read
    '{1'b1, 1'b1, 2'b10, 10'h1A2, A,  2'd0, 10'h1B2, W,                      8'd12}, // R12 ctrl A
    '{1'b0, 1'b0, 2'b00, 10'h1A0, A,  2'd0, 10'h1A0, A,                      8'd8},  // R8 no map
    '{1'b1, 1'b1, 2'b01, 10'h1A1, C2, 2'd1, 10'h1B1, 64'h0,                  8'd9}   // R9 fault quiet
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0, usr = 1'b0;
  logic [9:0]  num = '0;
  logic [63:0] wdata = '0, ctrl0 = '0, cur = '0;
  logic [9:0]  map_num, wr_num;
  logic        rsp_valid, wr_en, resync;
  logic [1:0]  fault;
  logic [63:0] rdata, wr_data;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pmu_user_gate i_pmu_user_gate (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(wr),
    .req_user_i(usr), .req_num_i(num), .req_wdata_i(wdata), .ctrl0_i(ctrl0),
    .cur_data_i(cur), .map_num_o(map_num), .rsp_valid_o(rsp_valid),
    .fault_o(fault), .rdata_o(rdata), .wr_en_o(wr_en), .wr_num_o(wr_num),
    .wr_data_o(wr_data), .resync_o(resync)
  );

  task automatic chk(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(9, "reset rsp_valid", 64'(rsp_valid), 64'h0);
    chk(9, "reset wr_en", 64'(wr_en), 64'h0);
    chk(9, "reset data", rdata | wr_data, 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      valid = 1'b1; wr = VEC[i].wr; usr = VEC[i].usr; num = VEC[i].num;
      wdata = W; cur = VEC[i].cur; ctrl0 = 64'(VEC[i].mode) << 18;
      #1;
      chk(7, "map_num", 64'(map_num), 64'(VEC[i].mnum));  // R7 mapping
      @(posedge clk); #1;
      begin
        logic wen;
        wen = VEC[i].wr && VEC[i].flt == 2'd0;
        chk(int'(VEC[i].req), "rsp_valid", 64'(rsp_valid), 64'h1);
        chk(int'(VEC[i].req), "fault", 64'(fault), 64'(VEC[i].flt));
        chk(int'(VEC[i].req), "wr_en", 64'(wr_en), 64'(wen));
        chk(int'(VEC[i].req), "rdata", rdata, VEC[i].wr ? 64'h0 : VEC[i].exp);
        chk(int'(VEC[i].req), "wr_data", wr_data, VEC[i].wr ? VEC[i].exp : 64'h0);
        if (wen) chk(7, "wr_num", 64'(wr_num), 64'(VEC[i].mnum));
        // R10 resync on control 0 writes only
        chk(10, "resync", 64'(resync), 64'(wen && VEC[i].mnum == 10'h1B0));
      end
    end

    // R9 idle cycle after traffic
    @(negedge clk);
    valid = 1'b0; wr = 1'b1; usr = 1'b1; num = 10'h1A0; ctrl0 = 64'(2'b11) << 18;
    @(posedge clk); #1;
    chk(9, "idle rsp_valid", 64'(rsp_valid), 64'h0);
    chk(9, "idle wr_en", 64'(wr_en), 64'h0);
    chk(10, "idle resync", 64'(resync), 64'h0);

    // R9 reset mid-run clears outputs
    @(negedge clk);
    valid = 1'b1; wr = 1'b1; usr = 1'b0; num = 10'h1B0;
    @(posedge clk); #1;
    chk(10, "pre-reset resync", 64'(resync), 64'h1);
    rst_n = 1'b0; #1;
    chk(9, "async reset wr_en", 64'(wr_en), 64'h0);
    chk(9, "async reset resync", 64'(resync), 64'h0);
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule